// File: doc/BRIEF.md
# Known-Answer Walking-Bit Vector Sequencer

This block generates, in order, the stimulus for a known-answer test of a 128-bit block cipher. After a start pulse it walks through a fixed set of tests. Each test offers a test number, a key and a data block on a valid/ready handshake, and a consumer (normally a cipher core plus a result checker) takes them one at a time. The block raises a one-cycle done flag after the last vector is accepted.

There are two walks. In the data walk the key stays all zero and each test sets one bit of the data block. In the key walk the data block stays all zero and each test sets one bit of a key that is 128, 192 or 256 bits long. Every set starts with an all-zero test 0. Test n sets pattern bit n-1. Bits are numbered from zero at the most significant end of the field, so pattern bit 0 is the top bit of the first hex digit and byte k spans bits 8k to 8k+7.

Top module: `katvec_sequencer`

## Requirements
- R1: After reset, `vec_valid` and `set_done` are 0, and they stay 0 until a start pulse arrives.
- R2: A `go` pulse while idle captures `walk_sel` (0 = data walk, 1 = key walk) and `klen_sel`. It raises `vec_valid` on the next cycle with `test_num` = 0 and both `key_out` and `data_out` all zero.
- R3: In the data walk, test n > 0 drives `data_out[127-(n-1)]` = 1 with every other data bit 0, and `key_out` is all zero.
- R4: The data walk has 129 vectors, numbered 0 to 128, whatever `klen_sel` is.
- R5: In the key walk with key length KL, test n > 0 drives `key_out[KL-1-(n-1)]` = 1 with every other key bit 0. This includes bits KL and above, which stay 0. `data_out` is all zero.
- R6: `klen_sel` encodes the key length as 0 = 128, 1 = 192, 2 = 256 and 3 = 256. The key walk has KL+1 vectors, numbered 0 to KL.
- R7: While `vec_valid` is 1 and `vec_ready` is 0, `vec_valid`, `test_num`, `key_out` and `data_out` hold their values on the next cycle.
- R8: `test_num` advances only on a cycle with `vec_valid` and `vec_ready` both 1, and then by exactly one.
- R9: `set_done` is 1 for exactly the one cycle after the final vector is accepted. `vec_valid` is 0 in that same cycle.
- R10: A `go` pulse, or a change of `walk_sel` or `klen_sel`, while a set is running has no effect on the running set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, taken only when idle |
| walk_sel | input | 1 | 0 = data walk, 1 = key walk |
| klen_sel | input | 2 | Key length code |
| vec_valid | output | 1 | Vector offered |
| vec_ready | input | 1 | Consumer accepts the vector |
| test_num | output | 9 | Test number of the offered vector |
| key_out | output | 256 | Key, pattern bit n at index KL-1-n |
| data_out | output | 128 | Data block, pattern bit n at index 127-n |
| set_done | output | 1 | One-cycle end-of-set flag |

## Verification
The bench builds the block with its defaults: a 128-bit block, a 256-bit key bus and a 9-bit counter. With these values every selectable key length can be walked right up to its last bit. That covers the 192-bit case, where the upper 64 key lines must stay zero, and the final index of the 256-bit walk at bus bit 0. Random ready patterns and stray start pulses during a run exercise the hold and ignore rules. Directed runs with ready held high cover back-to-back acceptance and the duplicate 256-bit code.

// File: rtl/katvec_pkg.sv
package katvec_pkg;

    typedef enum logic {
        WALK_DATA = 1'b0,
        WALK_KEY  = 1'b1
    } walk_e;

    typedef enum logic [1:0] {
        KSEL_128  = 2'd0,
        KSEL_192  = 2'd1,
        KSEL_256  = 2'd2,
        KSEL_256B = 2'd3
    } ksel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_st_e;

    // Key length in bits for a select code, limited to the key bus width.
    function automatic int unsigned key_bits(ksel_e s, int unsigned bus_w);
        int unsigned kb;
        case (s)
            KSEL_128: kb = 128;
            KSEL_192: kb = 192;
            default:  kb = 256;
        endcase
        return (kb > bus_w) ? bus_w : kb;
    endfunction

endpackage

// File: rtl/katvec_ctrl.sv
module katvec_ctrl
    import katvec_pkg::*;
#(
    parameter int BLK_W = 128,
    parameter int KEY_W = 256,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             walk_sel,
    input  logic [1:0]       klen_sel,
    input  logic             vec_ready,
    output logic             vec_valid,
    output logic [CNT_W-1:0] cnt,
    output walk_e            walk_q,
    output logic [CNT_W-1:0] klen_q,
    output logic             set_done
);

    localparam logic [CNT_W-1:0] BLK_LAST = CNT_W'(BLK_W);

    seq_st_e          st;
    logic [CNT_W-1:0] last_cnt;
    logic             accept;

    assign last_cnt  = (walk_q == WALK_DATA) ? BLK_LAST : klen_q;
    assign vec_valid = (st == ST_RUN);
    assign accept    = vec_valid && vec_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            walk_q   <= WALK_DATA;
            klen_q   <= '0;
            set_done <= 1'b0;
        end else begin
            set_done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (go) begin
                        st     <= ST_RUN;
                        cnt    <= '0;
                        walk_q <= walk_e'(walk_sel);
                        klen_q <= CNT_W'(key_bits(ksel_e'(klen_sel), KEY_W));
                    end
                end
                default: begin
                    if (accept) begin
                        if (cnt == last_cnt) begin
                            st       <= ST_IDLE;
                            set_done <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/katvec_pattern.sv
module katvec_pattern
    import katvec_pkg::*;
#(
    parameter int BLK_W = 128,
    parameter int KEY_W = 256,
    parameter int CNT_W = 9
) (
    input  walk_e            walk_q,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] klen_q,
    output logic [KEY_W-1:0] key_out,
    output logic [BLK_W-1:0] data_out
);

    localparam int EXT_W = CNT_W + 1;

    logic             cnt_nz;
    logic [EXT_W-1:0] cnt_ext;
    logic [EXT_W-1:0] klen_ext;

    assign cnt_nz   = (cnt != '0);
    assign cnt_ext  = {1'b0, cnt};
    assign klen_ext = {1'b0, klen_q};

    // Test n sets pattern bit n-1, carried on bus index W-n.
    for (genvar i = 0; i < BLK_W; i++) begin : g_data
        localparam logic [CNT_W-1:0] HIT = CNT_W'(BLK_W - i);
        assign data_out[i] = (walk_q == WALK_DATA) && (cnt == HIT);
    end

    for (genvar j = 0; j < KEY_W; j++) begin : g_key
        localparam logic [EXT_W-1:0] POS = EXT_W'(j);
        assign key_out[j] = (walk_q == WALK_KEY) && cnt_nz
                            && ((cnt_ext + POS) == klen_ext);
    end

endmodule

// File: rtl/katvec_sequencer.sv
module katvec_sequencer
    import katvec_pkg::*;
#(
    parameter int BLK_W = 128,
    parameter int KEY_W = 256,
    localparam int CNT_W = $clog2(((KEY_W > BLK_W) ? KEY_W : BLK_W) + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             walk_sel,
    input  logic [1:0]       klen_sel,
    output logic             vec_valid,
    input  logic             vec_ready,
    output logic [CNT_W-1:0] test_num,
    output logic [KEY_W-1:0] key_out,
    output logic [BLK_W-1:0] data_out,
    output logic             set_done
);

    walk_e            walk_q;
    logic [CNT_W-1:0] klen_q;
    logic [CNT_W-1:0] cnt;

    katvec_ctrl #(.BLK_W(BLK_W), .KEY_W(KEY_W), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .walk_sel  (walk_sel),
        .klen_sel  (klen_sel),
        .vec_ready (vec_ready),
        .vec_valid (vec_valid),
        .cnt       (cnt),
        .walk_q    (walk_q),
        .klen_q    (klen_q),
        .set_done  (set_done)
    );

    katvec_pattern #(.BLK_W(BLK_W), .KEY_W(KEY_W), .CNT_W(CNT_W)) u_pat (
        .walk_q   (walk_q),
        .cnt      (cnt),
        .klen_q   (klen_q),
        .key_out  (key_out),
        .data_out (data_out)
    );

    assign test_num = cnt;

endmodule

// File: rtl/katvec_checks.sv
module katvec_checks #(
    parameter int BLK_W = 128,
    parameter int KEY_W = 256,
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             vec_valid,
    input logic             vec_ready,
    input logic [CNT_W-1:0] test_num,
    input logic [KEY_W-1:0] key_out,
    input logic [BLK_W-1:0] data_out,
    input logic             set_done
);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        vec_valid && !vec_ready |=> vec_valid && $stable(test_num)
                                    && $stable(key_out) && $stable(data_out));

    p_step_r8: assert property (@(posedge clk) disable iff (rst)
        $past(vec_valid && vec_ready) && vec_valid |-> test_num == $past(test_num) + 1'b1);

    p_zero_first_r2: assert property (@(posedge clk) disable iff (rst)
        vec_valid && test_num == '0 |-> key_out == '0 && data_out == '0);

    p_single_bit_r3: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $onehot0(data_out) && $onehot0(key_out));

    p_one_side_r5: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> key_out == '0 || data_out == '0);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        set_done |=> !set_done);

    p_done_cause_r9: assert property (@(posedge clk) disable iff (rst)
        set_done |-> !vec_valid && $past(vec_valid && vec_ready));

endmodule

bind katvec_sequencer katvec_checks #(.BLK_W(BLK_W), .KEY_W(KEY_W), .CNT_W(CNT_W)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .vec_valid (vec_valid),
    .vec_ready (vec_ready),
    .test_num  (test_num),
    .key_out   (key_out),
    .data_out  (data_out),
    .set_done  (set_done)
);

// File: tb/katvec_sequencer_test.sv
module katvec_sequencer_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         go = 1'b0;
    logic         walk_sel = 1'b0;
    logic [1:0]   klen_sel = 2'd0;
    logic         vec_ready = 1'b0;
    logic         vec_valid;
    logic [8:0]   test_num;
    logic [255:0] key_out;
    logic [127:0] data_out;
    logic         set_done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    katvec_sequencer uut (
        .clk(clk), .rst(rst), .go(go), .walk_sel(walk_sel), .klen_sel(klen_sel),
        .vec_valid(vec_valid), .vec_ready(vec_ready), .test_num(test_num),
        .key_out(key_out), .data_out(data_out), .set_done(set_done)
    );

    always #5 clk = ~clk;

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: act=hung exp=finished");
            report();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int kl_of(input logic [1:0] s);
        return (s == 2'd0) ? 128 : (s == 2'd1) ? 192 : 256;
    endfunction

    function automatic logic [127:0] e_data(input logic m, input int n);
        logic [127:0] v = '0;
        if (!m && n > 0) v[128 - n] = 1'b1;
        return v;
    endfunction

    function automatic logic [255:0] e_key(input logic m, input int n, input int kl);
        logic [255:0] v = '0;
        if (m && n > 0) v[kl - n] = 1'b1;
        return v;
    endfunction

    task automatic run_seq(input logic m, input logic [1:0] ks, input int rdy_pct, input bit poke);
        int kl   = kl_of(ks);
        int last = m ? kl : 128;
        int n    = 0;
        bit acc;
        string tg;
        @(negedge clk);
        go = 1'b1; walk_sel = m; klen_sel = ks; vec_ready = 1'b0;
        @(negedge clk);
        go = 1'b0;
        forever begin
            tg = (n == 0) ? "R2" : (m ? "R5" : "R3");
            chk(vec_valid == 1'b1, "R2 valid", 256'(vec_valid), 256'd1);
            chk(test_num == 9'(n), "R8 test_num", 256'(test_num), 256'(n));
            chk(data_out == e_data(m, n), {tg, " data"}, 256'(data_out), 256'(e_data(m, n)));
            chk(key_out == e_key(m, n, kl), {tg, " key R6"}, key_out, e_key(m, n, kl));
            chk(set_done == 1'b0, "R9 early done", 256'(set_done), 256'd0);
            acc = (($urandom % 100) < rdy_pct);
            vec_ready = acc;
            if (poke && ($urandom % 4 == 0)) begin
                go = 1'b1; walk_sel = ~m; klen_sel = 2'($urandom); // R10 stray start
            end else begin
                go = 1'b0;
            end
            @(negedge clk);
            if (acc) begin
                if (n == last) break;
                n++;
            end
        end
        go = 1'b0; vec_ready = 1'b0;
        chk(set_done == 1'b1, m ? "R6 done" : "R4 done", 256'(set_done), 256'd1);
        chk(vec_valid == 1'b0, "R9 valid low", 256'(vec_valid), 256'd0);
        @(negedge clk);
        chk(set_done == 1'b0, "R9 pulse", 256'(set_done), 256'd0);
        chk(vec_valid == 1'b0, "R10 no restart", 256'(vec_valid), 256'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk(vec_valid == 1'b0, "R1 valid", 256'(vec_valid), 256'd0);
            chk(set_done == 1'b0, "R1 done", 256'(set_done), 256'd0);
        end
        run_seq(1'b0, 2'd0, 100, 1'b0);  // R4 back-to-back data walk
        run_seq(1'b1, 2'd0, 100, 1'b0);  // R6 128-bit key walk
        run_seq(1'b1, 2'd1, 60, 1'b1);   // R5 192-bit key, upper lines zero
        run_seq(1'b1, 2'd2, 50, 1'b1);   // R6 256-bit key walk
        run_seq(1'b1, 2'd3, 70, 1'b0);   // R6 duplicate 256 code
        run_seq(1'b0, 2'd2, 35, 1'b1);   // R7 heavy back-pressure
        for (int k = 0; k < 4; k++) begin
            run_seq(1'($urandom), 2'($urandom), 30 + int'($urandom % 70), 1'b1);
        end
        report();
        $finish;
    end

endmodule